// File: doc/BRIEF.md
# Multiplexed Asynchronous Bus Access Sequencer

This block carries out one read or one write at a time on a 16-bit external bus where address and data share the same pins. A request from the internal side carries an address, write data, a lane mask and a direction. The sequencer then moves through a fixed set of phases. First it drives the address. An optional extra cycle keeps the address on the pins. A programmable delay follows, with every strobe idle. Last comes the command phase, in which the read strobe or the write strobe is held low. At the end of the command phase a read captures the bus value. In every case the block raises a one-cycle completion pulse on its way back to idle.

The controller has six states. ST_IDLE waits for a request. ST_ADDR drives the address for one cycle. ST_AHOLD is an optional single cycle that keeps driving the address. ST_CDLY lasts 0 to 7 cycles; with a setting of 0 it is skipped. ST_CMD is the programmed command part. ST_WAITX is the part of the command that is extended by WAIT. The transitions are:
- accept: ST_IDLE to ST_ADDR.
- to_hold: ST_ADDR to ST_AHOLD.
- to_delay: ST_ADDR or ST_AHOLD to ST_CDLY.
- to_cmd: ST_ADDR, ST_AHOLD or ST_CDLY to ST_CMD.
- extend: ST_CMD to ST_WAITX.
- finish: ST_CMD or ST_WAITX to ST_IDLE.

The read and write command lengths are set separately. WAIT extension can be turned on or off. The byte-lane strobes either follow the command strobe or span the whole access.

Top module: `async_bus_seq`

## Requirements
- R1: `req_ready` is high only in idle. A request with `req_valid` high in an idle cycle starts an access. The next cycle is the only cycle of that access with `adv_n` low, and in it `ad_oe`=1 and `ad_out` equals the request address. A `req_valid` seen while busy is ignored.
- R2: With `cfg_ahold_en`=1, one cycle follows the address cycle in which `adv_n`, `rd_n` and `rdwr_n` are all high.
- R3: After the address cycle (and the hold cycle, if enabled), exactly `cfg_cmd_dly` cycles (0 to 7) pass with all strobes high before the command phase. A value of 0 adds no cycle.
- R4: The programmed command phase lasts `cfg_rd_len` cycles for a read and `cfg_wr_len` cycles for a write. A value of 0 gives one cycle.
- R5: Reads (`req_write`=0): in every command cycle `rd_n`=0, `rdwr_n`=1 and `ad_oe`=0.
- R6: Writes (`req_write`=1): in every command cycle `rdwr_n`=0, `rd_n`=1, `ad_oe`=1 and `ad_out` equals the write data.
- R7: Bit i of `bc_n` serves byte lane i (bit 0 is AD[7:0]) and is low only when `req_be[i]`=1. With `cfg_bc_follow`=1 it is low in exactly the command cycles. With `cfg_bc_follow`=0 it is low from the address cycle through the last command cycle.
- R8: With `cfg_wait_en`=1, `wait_in` (active high) is synchronized through two flops and then sampled in the last programmed command cycle. While the synchronized value is high, the command phase is extended. If `wait_in` falls during command cycle k (counted from 1), the phase ends after cycle k+2.
- R9: With `cfg_wait_en`=0, `wait_in` is ignored and the command phase lasts exactly its programmed length.
- R10: `rsp_done` is high for exactly one cycle: the first cycle after the command phase. For a read, `rsp_rdata` then holds the value `ad_in` had in the last command cycle. `rsp_rdata` keeps that value through later writes.
- R11: After reset the block is idle. `rd_n`, `rdwr_n` and `adv_n` are 1, `bc_n` is all ones, `ad_oe`=0, `rsp_done`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte-lane mask |
| req_ready | output | 1 | Idle, a request is accepted |
| rsp_rdata | output | 16 | Captured read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| cfg_ahold_en | input | 1 | Enables the address-hold cycle |
| cfg_cmd_dly | input | 3 | Command-delay cycles |
| cfg_rd_len | input | 4 | Read command cycles |
| cfg_wr_len | input | 4 | Write command cycles |
| cfg_wait_en | input | 1 | Enables WAIT extension |
| cfg_bc_follow | input | 1 | Byte strobes follow the command strobe |
| ad_out | output | 16 | Multiplexed address/data out |
| ad_oe | output | 1 | Output enable for the AD pins |
| ad_in | input | 16 | Multiplexed data in |
| adv_n | output | 1 | Address-valid strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| rdwr_n | output | 1 | Write strobe, active low |
| bc_n | output | 2 | Byte-lane strobes, active low |
| wait_in | input | 1 | External extension request, active high |

## Verification
The assertions assume that the configuration inputs do not change while an access is in progress. The check that the delay state is entered only for a nonzero delay depends on this. The assertions judge WAIT only through its synchronized copy. The stimulus therefore changes configuration only while the block is idle, and it sets `wait_in` at least three cycles before a request. It releases `wait_in` only on falling clock edges. `ad_in` is held steady for the whole of each read.

// File: rtl/abs_pkg.sv
package abs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_AHOLD = 3'd2,
        ST_CDLY  = 3'd3,
        ST_CMD   = 3'd4,
        ST_WAITX = 3'd5
    } seq_state_e;

endpackage

// File: rtl/abs_sync.sv
module abs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/abs_phase_timer.sv
module abs_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - W'(1);
    end

    assign last = (cnt == '0);

    // R4: an idle timer stays expired until reloaded
    p_timer_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && last) |=> last);
endmodule

// File: rtl/abs_pad_drive.sv
module abs_pad_drive
    import abs_pkg::*;
#(
    parameter int DW  = 16,
    parameter int BEW = DW / 8
) (
    input  seq_state_e       state,
    input  logic             lat_wr,
    input  logic [DW-1:0]    lat_addr,
    input  logic [DW-1:0]    lat_wdata,
    input  logic [BEW-1:0]   lat_be,
    input  logic             bc_follow,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    output logic             adv_n,
    output logic             rd_n,
    output logic             rdwr_n,
    output logic [BEW-1:0]   bc_n
);
    logic in_cmd;
    logic bc_span;

    always_comb begin
        ad_out  = lat_addr;
        ad_oe   = 1'b0;
        adv_n   = 1'b1;
        rd_n    = 1'b1;
        rdwr_n  = 1'b1;
        in_cmd  = 1'b0;
        bc_span = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_ADDR: begin
                adv_n   = 1'b0;
                ad_oe   = 1'b1;
                bc_span = 1'b1;
            end
            ST_AHOLD: begin
                ad_oe   = 1'b1;
                bc_span = 1'b1;
            end
            ST_CDLY: begin
                bc_span = 1'b1;
            end
            ST_CMD, ST_WAITX: begin
                in_cmd  = 1'b1;
                bc_span = 1'b1;
                if (lat_wr) begin
                    rdwr_n = 1'b0;
                    ad_oe  = 1'b1;
                    ad_out = lat_wdata;
                end else begin
                    rd_n   = 1'b0;
                end
            end
            default: begin
            end
        endcase
    end

    generate
        for (genvar b = 0; b < BEW; b++) begin : g_lane
            assign bc_n[b] = !(lat_be[b] && (bc_follow ? in_cmd : bc_span));
        end
    endgenerate
endmodule

// File: rtl/async_bus_seq.sv
module async_bus_seq
    import abs_pkg::*;
#(
    parameter int DW       = 16,
    parameter int CDW      = 3,
    parameter int CLW      = 4,
    parameter int SYNC_STG = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [DW-1:0]      req_addr,
    input  logic [DW-1:0]      req_wdata,
    input  logic [DW/8-1:0]    req_be,
    output logic               req_ready,
    output logic [DW-1:0]      rsp_rdata,
    output logic               rsp_done,
    input  logic               cfg_ahold_en,
    input  logic [CDW-1:0]     cfg_cmd_dly,
    input  logic [CLW-1:0]     cfg_rd_len,
    input  logic [CLW-1:0]     cfg_wr_len,
    input  logic               cfg_wait_en,
    input  logic               cfg_bc_follow,
    output logic [DW-1:0]      ad_out,
    output logic               ad_oe,
    input  logic [DW-1:0]      ad_in,
    output logic               adv_n,
    output logic               rd_n,
    output logic               rdwr_n,
    output logic [DW/8-1:0]    bc_n,
    input  logic               wait_in
);
    localparam int BEW = DW / 8;
    localparam int TW  = (CDW > CLW) ? CDW : CLW;

    seq_state_e     state, nxt;
    logic           lat_wr;
    logic [DW-1:0]  lat_addr, lat_wdata;
    logic [BEW-1:0] lat_be;
    logic           wait_s, hold_cmd;
    logic           t_load, t_last;
    logic [TW-1:0]  t_val, dly_m1, cmd_m1;
    logic [CLW-1:0] cmd_len;
    logic           accept, finish;

    abs_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(wait_in), .q(wait_s)
    );

    abs_phase_timer #(.W(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .last(t_last)
    );

    assign accept   = (state == ST_IDLE) && req_valid;
    assign hold_cmd = cfg_wait_en && wait_s;
    assign cmd_len  = lat_wr ? cfg_wr_len : cfg_rd_len;
    assign dly_m1   = TW'(cfg_cmd_dly) - TW'(1);
    assign cmd_m1   = (cmd_len == '0) ? '0 : (TW'(cmd_len) - TW'(1));
    assign finish   = ((state == ST_CMD) && t_last && !hold_cmd) ||
                      ((state == ST_WAITX) && !hold_cmd);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next-state and timer loading
    always_comb begin
        nxt    = state;
        t_load = 1'b0;
        t_val  = '0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) nxt = ST_ADDR;
            end
            ST_ADDR, ST_AHOLD: begin
                if (state == ST_ADDR && cfg_ahold_en) begin
                    nxt = ST_AHOLD;
                end else if (cfg_cmd_dly != '0) begin
                    nxt    = ST_CDLY;
                    t_load = 1'b1;
                    t_val  = dly_m1;
                end else begin
                    nxt    = ST_CMD;
                    t_load = 1'b1;
                    t_val  = cmd_m1;
                end
            end
            ST_CDLY: begin
                if (t_last) begin
                    nxt    = ST_CMD;
                    t_load = 1'b1;
                    t_val  = cmd_m1;
                end
            end
            ST_CMD: begin
                if (t_last) nxt = hold_cmd ? ST_WAITX : ST_IDLE;
            end
            ST_WAITX: begin
                if (!hold_cmd) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_wr    <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_be    <= '0;
        end else if (accept) begin
            lat_wr    <= req_write;
            lat_addr  <= req_addr;
            lat_wdata <= req_wdata;
            lat_be    <= req_be;
        end
    end

    // completion and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= finish;
            if (finish && !lat_wr) rsp_rdata <= ad_in;
        end
    end

    assign req_ready = (state == ST_IDLE);

    abs_pad_drive #(.DW(DW), .BEW(BEW)) u_pads (
        .state(state), .lat_wr(lat_wr), .lat_addr(lat_addr),
        .lat_wdata(lat_wdata), .lat_be(lat_be), .bc_follow(cfg_bc_follow),
        .ad_out(ad_out), .ad_oe(ad_oe), .adv_n(adv_n), .rd_n(rd_n),
        .rdwr_n(rdwr_n), .bc_n(bc_n)
    );

    p_accept_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!adv_n && ad_oe));
    p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_n |-> !req_ready);
    p_hold_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AHOLD) |-> (adv_n && rd_n && rdwr_n));
    p_delay_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CDLY) |-> (cfg_cmd_dly != '0));
    p_read_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (!ad_oe && rdwr_n));
    p_write_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rdwr_n |-> (ad_oe && rd_n));
    p_bc_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_bc_follow && rd_n && rdwr_n) |-> (&bc_n));
    p_no_extend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wait_en |-> (state != ST_WAITX));
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    p_done_after_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !rdwr_n) && (nxt == ST_IDLE) |=> rsp_done);
endmodule

// File: tb/async_bus_seq_test.sv
module async_bus_seq_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [1:0]  be;
        logic        ahold;
        logic [2:0]  cdly;
        logic [3:0]  rdlen;
        logic [3:0]  wrlen;
        logic        follow;
        logic        waiten;
        logic        waitin;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 16'h1234, 16'h0000, 2'b11, 1'b0, 3'd0, 4'd1,  4'd5, 1'b1, 1'b0, 1'b0},
        '{1'b1, 16'h2000, 16'hBEEF, 2'b01, 1'b1, 3'd2, 4'd3,  4'd4, 1'b1, 1'b0, 1'b0},
        '{1'b0, 16'h3456, 16'h0000, 2'b10, 1'b0, 3'd7, 4'd0,  4'd2, 1'b0, 1'b0, 1'b0},
        '{1'b1, 16'h4001, 16'hA5C3, 2'b11, 1'b1, 3'd0, 4'd9,  4'd0, 1'b0, 1'b0, 1'b0},
        '{1'b0, 16'h5A5A, 16'h0000, 2'b11, 1'b1, 3'd3, 4'd15, 4'd1, 1'b1, 1'b1, 1'b0},
        '{1'b1, 16'h6002, 16'h1357, 2'b10, 1'b0, 3'd7, 4'd2,  4'd7, 1'b1, 1'b0, 1'b1},
        '{1'b0, 16'h7FFE, 16'h0000, 2'b01, 1'b0, 3'd1, 4'd4,  4'd3, 1'b1, 1'b0, 1'b1},
        '{1'b1, 16'h8000, 16'h2468, 2'b00, 1'b0, 3'd0, 4'd2,  4'd3, 1'b1, 1'b0, 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0, ad_in = '0;
    logic [1:0] req_be = '0;
    logic cfg_ahold_en = 1'b0, cfg_wait_en = 1'b0, cfg_bc_follow = 1'b1;
    logic [2:0] cfg_cmd_dly = '0;
    logic [3:0] cfg_rd_len = 4'd1, cfg_wr_len = 4'd1;
    logic wait_in = 1'b0;
    logic req_ready, rsp_done, ad_oe, adv_n, rd_n, rdwr_n;
    logic [15:0] rsp_rdata, ad_out;
    logic [1:0] bc_n;

    int checks = 0, failures = 0;
    int n_addr, n_gap, n_cmd, bc_cnt, busy_ready;
    bit addr_ok, cmd_ok, bc_ok, done_seen, done_after;

    always #(CLK_PERIOD/2) clk = ~clk;

    async_bus_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .cfg_ahold_en(cfg_ahold_en), .cfg_cmd_dly(cfg_cmd_dly),
        .cfg_rd_len(cfg_rd_len), .cfg_wr_len(cfg_wr_len),
        .cfg_wait_en(cfg_wait_en), .cfg_bc_follow(cfg_bc_follow),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .adv_n(adv_n),
        .rd_n(rd_n), .rdwr_n(rdwr_n), .bc_n(bc_n), .wait_in(wait_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Drives one access from a falling edge and classifies every cycle until done.
    task automatic do_access(input logic wr, input logic [15:0] addr,
                             input logic [15:0] wdata, input logic [1:0] be,
                             input int drop_at, input bit inject);
        bit injected = 0;
        n_addr = 0; n_gap = 0; n_cmd = 0; bc_cnt = 0; busy_ready = -1;
        addr_ok = 1; cmd_ok = 1; bc_ok = 1;
        ad_in = ~addr;
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wdata; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (rsp_done) break;
            req_valid = 1'b0;
            if (!adv_n) begin
                n_addr++;
                if (!(ad_oe && ad_out == addr && rd_n && rdwr_n)) addr_ok = 0;
            end else if (rd_n && rdwr_n) begin
                n_gap++;
                if (inject && !injected) begin
                    injected = 1;
                    busy_ready = int'(req_ready);
                    req_valid = 1'b1;
                    req_addr = 16'hDEAD;
                end
            end else begin
                n_cmd++;
                if (wr) begin
                    if (!(!rdwr_n && rd_n && ad_oe && ad_out == wdata)) cmd_ok = 0;
                end else begin
                    if (!(!rd_n && rdwr_n && !ad_oe)) cmd_ok = 0;
                end
                if (drop_at > 0 && n_cmd == drop_at) wait_in = 1'b0;
            end
            if (bc_n != 2'b11) begin
                bc_cnt++;
                if (bc_n !== ~be) bc_ok = 0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        done_seen = rsp_done;
        @(negedge clk);
        done_after = rsp_done;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] last_rd;
        last_rd = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        chk(rd_n && rdwr_n && adv_n && bc_n == 2'b11 && !ad_oe && !rsp_done && req_ready,
            "R11 reset idle outputs", {rd_n, rdwr_n, adv_n, bc_n, ad_oe, rsp_done, req_ready}, 8'b11111001);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            int exp_cmd, exp_gap, exp_bc;
            vec_t t;
            t = VECS[v];
            cfg_ahold_en = t.ahold; cfg_cmd_dly = t.cdly;
            cfg_rd_len = t.rdlen; cfg_wr_len = t.wrlen;
            cfg_bc_follow = t.follow; cfg_wait_en = t.waiten; wait_in = t.waitin;
            repeat (3) @(negedge clk);
            do_access(t.wr, t.addr, t.wdata, t.be, 0, 0);
            exp_cmd = t.wr ? int'(t.wrlen) : int'(t.rdlen);
            if (exp_cmd == 0) exp_cmd = 1;
            exp_gap = int'(t.ahold) + int'(t.cdly);
            exp_bc  = (t.be == 2'b00) ? 0 : (t.follow ? exp_cmd : 1 + exp_gap + exp_cmd);
            chk(n_addr == 1 && addr_ok, "R1 single address cycle", n_addr, 1);
            chk(n_gap == exp_gap, "R2/R3 hold+delay cycles", n_gap, exp_gap);
            chk(n_cmd == exp_cmd, t.waitin ? "R9 wait ignored length" : "R4 command length", n_cmd, exp_cmd);
            chk(cmd_ok, t.wr ? "R6 write command pins" : "R5 read command pins", cmd_ok, 1);
            chk(bc_ok && bc_cnt == exp_bc, "R7 byte strobes", bc_cnt, exp_bc);
            chk(done_seen && !done_after, "R10 done pulse", {done_seen, done_after}, 2);
            if (!t.wr) last_rd = ~t.addr;
            chk(rsp_rdata == last_rd, "R10 read data", rsp_rdata, last_rd);
        end

        // R8: wait extension, release in command cycle 4 of 2 programmed
        cfg_ahold_en = 0; cfg_cmd_dly = 3'd1; cfg_rd_len = 4'd2; cfg_wait_en = 1;
        cfg_bc_follow = 1; wait_in = 1'b1;
        repeat (3) @(negedge clk);
        do_access(1'b0, 16'h0C0C, 16'h0, 2'b11, 4, 0);
        chk(n_cmd == 6, "R8 extended command length", n_cmd, 6);
        chk(cmd_ok && bc_cnt == 6, "R8 strobes held through extension", bc_cnt, 6);
        chk(rsp_rdata == 16'hF3F3, "R8 read data after extension", rsp_rdata, 16'hF3F3);

        // R8: release in the last programmed cycle
        cfg_wr_len = 4'd3; wait_in = 1'b1;
        repeat (3) @(negedge clk);
        do_access(1'b1, 16'h0D0D, 16'h7777, 2'b01, 3, 0);
        chk(n_cmd == 5, "R8 release at last programmed cycle", n_cmd, 5);
        chk(rsp_rdata == 16'hF3F3, "R10 read data kept over write", rsp_rdata, 16'hF3F3);

        // R1: request while busy is ignored
        cfg_wait_en = 0; wait_in = 1'b0; cfg_cmd_dly = 3'd3; cfg_rd_len = 4'd4;
        repeat (3) @(negedge clk);
        do_access(1'b0, 16'h0E0E, 16'h0, 2'b11, 0, 1);
        chk(busy_ready == 0, "R1 not ready while busy", busy_ready, 0);
        begin
            int adv_seen = 0;
            for (int i = 0; i < 4; i++) begin
                if (!adv_n) adv_seen++;
                @(negedge clk);
            end
            chk(adv_seen == 0, "R1 busy request ignored", adv_seen, 0);
        end
        chk(rsp_rdata == 16'hF1F1, "R10 read data of last read", rsp_rdata, 16'hF1F1);

        summary();
        $finish;
    end
endmodule